// File: doc/BRIEF.md
# Boot strap sampler and decoder

This block reads a set of resistor-strapped pins while the chip is held in reset. At the first clock after reset is released it latches their value once, and it decodes that value into the boot configuration the rest of the chip needs. The configuration selects one boot device: a parallel NOR flash or ROM, a parallel NAND flash, host-assisted start, or a serial EEPROM on an I2C bus. It also gives the parallel data width and the I2C clock rate. For host-assisted start, the block drives a default subsystem ID and a default vendor ID.

The strap pins pass through a two-flop synchronizer before they are latched. The latched code holds until the next reset. One cycle after capture, the block hands the pins to the general-purpose I/O logic. The low three strap bits choose the mode. Strap bit 2 means data width in the parallel modes and bus speed in the EEPROM mode. Any set bit above bit 2 marks the code as reserved.

Top module: `boot_strap_ctl`

## Requirements
- R1: While `rst_n` is low, `captured`, `gpio_own`, `boot_sel`, `mode_code`, `wide_bus`, `i2c_fast`, `reserved_err`, `subsys_id` and `vendor_id` are all zero.
- R2: The value latched into `mode_code` is the value the strap pins held before the clock edge two edges ahead of the first edge with `rst_n` high. `captured` rises on that first edge.
- R3: After capture, changes on `strap_pins` have no effect on any decoded output until the next reset. A new reset clears the outputs and latches the straps again.
- R4: Codes 000 and 100 on bits [2:0] select parallel NOR/ROM boot (`boot_sel` bit 0). `wide_bus` equals bit 2, where 1 means 16-bit and 0 means 8-bit.
- R5: Codes 001 and 101 select parallel NAND boot (`boot_sel` bit 1). `wide_bus` equals bit 2.
- R6: Codes 010 and 110 select host-assisted boot (`boot_sel` bit 2). `subsys_id` reads 0x1234 and `vendor_id` reads 0x5678. In every other mode both IDs are zero.
- R7: Codes 011 and 111 select serial EEPROM boot (`boot_sel` bit 3). `i2c_fast` equals bit 2, where 1 means 400 kHz and 0 means 100 kHz. `wide_bus` is 0 in the host and EEPROM modes, and `i2c_fast` is 0 outside the EEPROM mode.
- R8: If any strap bit above bit 2 is set, `reserved_err` is 1 once the code is captured. In that case `boot_sel`, `wide_bus`, `i2c_fast` and both IDs are zero.
- R9: `gpio_own` rises exactly one clock after `captured` and stays high until reset.
- R10: After capture and without a reserved code, exactly one bit of `boot_sel` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| strap_pins | input | STRAP_W | Resistor strap pins |
| mode_code | output | STRAP_W | Latched strap code |
| boot_sel | output | 4 | One-hot select: 0 NOR, 1 NAND, 2 host, 3 EEPROM |
| wide_bus | output | 1 | Parallel data width is 16 bits |
| i2c_fast | output | 1 | EEPROM bus runs at 400 kHz |
| reserved_err | output | 1 | Captured code is reserved |
| captured | output | 1 | Straps have been latched |
| gpio_own | output | 1 | Pins handed to GPIO logic |
| subsys_id | output | ID_W | Default subsystem ID in host mode |
| vendor_id | output | ID_W | Default vendor ID in host mode |

## Verification
The hardest case to reach from the ports is the synchronizer latency at reset release. A strap change that arrives only one edge before release must not be captured, and one that arrives two edges before must be. To reach it, the bench holds one value through a long reset and then switches to a second value at a chosen falling edge. It then counts off exactly one or two rising edges before releasing `rst_n`, and compares `mode_code` with the old and new values.

// File: rtl/boot_strap_ctl.sv
module boot_strap_ctl #(
  parameter int STRAP_W = 8,
  parameter int ID_W = 16,
  parameter logic [ID_W-1:0] SUBSYS_DEF = 16'h1234,
  parameter logic [ID_W-1:0] VENDOR_DEF = 16'h5678
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_pins,
  output logic [STRAP_W-1:0] mode_code,
  output logic [3:0]         boot_sel,
  output logic               wide_bus,
  output logic               i2c_fast,
  output logic               reserved_err,
  output logic               captured,
  output logic               gpio_own,
  output logic [ID_W-1:0]    subsys_id,
  output logic [ID_W-1:0]    vendor_id
);
  logic [STRAP_W-1:0] sync1, sync2, code_q;
  logic               cap_q, gpio_q, upper_set, valid;
  logic [2:0]         low;

  always_ff @(posedge clk) begin
    sync1 <= strap_pins;
    sync2 <= sync1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      gpio_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (!cap_q) begin
        cap_q  <= 1'b1;
        code_q <= sync2;
      end
      gpio_q <= cap_q;
    end
  end

  generate
    if (STRAP_W > 3) begin : g_upper
      assign upper_set = |code_q[STRAP_W-1:3];
    end else begin : g_no_upper
      assign upper_set = 1'b0;
    end
  endgenerate

  assign low          = code_q[2:0];
  assign valid        = cap_q & ~upper_set;
  assign boot_sel     = valid ? {low[1:0] == 2'b11, low[1:0] == 2'b10,
                                 low[1:0] == 2'b01, low[1:0] == 2'b00} : 4'b0000;
  assign wide_bus     = (boot_sel[0] | boot_sel[1]) & low[2];
  assign i2c_fast     = boot_sel[3] & low[2];
  assign reserved_err = cap_q & upper_set;
  assign mode_code    = code_q;
  assign captured     = cap_q;
  assign gpio_own     = gpio_q;
  assign subsys_id    = boot_sel[2] ? SUBSYS_DEF : '0;
  assign vendor_id    = boot_sel[2] ? VENDOR_DEF : '0;
endmodule

module boot_strap_chk #(
  parameter int STRAP_W = 8,
  parameter int ID_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [STRAP_W-1:0] mode_code,
  input logic [3:0]         boot_sel,
  input logic               wide_bus,
  input logic               i2c_fast,
  input logic               reserved_err,
  input logic               captured,
  input logic               gpio_own,
  input logic [ID_W-1:0]    subsys_id
);
  a_r3_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> ($stable(mode_code) && $stable(boot_sel)));
  a_r9_gpio_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> gpio_own);
  a_r9_gpio_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_own |-> captured);
  a_r10_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(boot_sel));
  a_r10_sel_one_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && !reserved_err) |-> ($countones(boot_sel) == 1));
  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_err |-> (boot_sel == 4'b0000 && !wide_bus && !i2c_fast));
  a_r6_id_only_host: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_sel[2] |-> (subsys_id == '0));
  a_r7_fast_only_eeprom: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_fast |-> boot_sel[3]);
endmodule

bind boot_strap_ctl boot_strap_chk #(.STRAP_W(STRAP_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .boot_sel(boot_sel),
  .wide_bus(wide_bus), .i2c_fast(i2c_fast), .reserved_err(reserved_err),
  .captured(captured), .gpio_own(gpio_own), .subsys_id(subsys_id)
);

// File: tb/boot_strap_ctl_tb.sv
module boot_strap_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  strap_pins = 8'h00;
  logic [7:0]  mode_code;
  logic [3:0]  boot_sel;
  logic        wide_bus, i2c_fast, reserved_err, captured, gpio_own;
  logic [15:0] subsys_id, vendor_id;
  int          n_run = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  boot_strap_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins), .mode_code(mode_code),
    .boot_sel(boot_sel), .wide_bus(wide_bus), .i2c_fast(i2c_fast),
    .reserved_err(reserved_err), .captured(captured), .gpio_own(gpio_own),
    .subsys_id(subsys_id), .vendor_id(vendor_id)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic boot(input logic [7:0] v);
    @(negedge clk) rst_n = 1'b0;
    strap_pins = v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_mode(input logic [7:0] v);
    logic [3:0]  es;
    logic        ew, ef, er;
    logic [15:0] eid_s, eid_v;
    er = |v[7:3];
    es = er ? 4'b0000 : (4'b0001 << v[1:0]);
    ew = (es[0] | es[1]) & v[2];
    ef = es[3] & v[2];
    eid_s = es[2] ? 16'h1234 : 16'h0000;
    eid_v = es[2] ? 16'h5678 : 16'h0000;
    boot(v);
    check("R2 mode_code", {24'd0, mode_code}, {24'd0, v});
    check(es[0] ? "R4 sel" : es[1] ? "R5 sel" : es[2] ? "R6 sel" : es[3] ? "R7 sel" : "R8 sel",
          {28'd0, boot_sel}, {28'd0, es});
    check("R4 R5 wide_bus", {31'd0, wide_bus}, {31'd0, ew});
    check("R7 i2c_fast", {31'd0, i2c_fast}, {31'd0, ef});
    check("R8 reserved_err", {31'd0, reserved_err}, {31'd0, er});
    check("R6 subsys_id", {16'd0, subsys_id}, {16'd0, eid_s});
    check("R6 vendor_id", {16'd0, vendor_id}, {16'd0, eid_v});
    check("R10 sel count", $countones(boot_sel), er ? 0 : 1);
  endtask

  task automatic t_reset_state();
    @(negedge clk) rst_n = 1'b0;
    strap_pins = 8'h02;
    repeat (3) @(negedge clk);
    check("R1 captured", {31'd0, captured}, 0);
    check("R1 gpio_own", {31'd0, gpio_own}, 0);
    check("R1 boot_sel", {28'd0, boot_sel}, 0);
    check("R1 mode_code", {24'd0, mode_code}, 0);
    check("R1 flags", {29'd0, wide_bus, i2c_fast, reserved_err}, 0);
    check("R1 ids", {subsys_id, vendor_id}, 0);
  endtask

  task automatic t_handover();
    boot(8'h04);
    check("R2 captured first edge", {31'd0, captured}, 1);
    check("R9 gpio_own not yet", {31'd0, gpio_own}, 0);
    @(negedge clk);
    check("R9 gpio_own one cycle later", {31'd0, gpio_own}, 1);
    repeat (5) @(negedge clk);
    check("R9 gpio_own stays", {31'd0, gpio_own}, 1);
  endtask

  task automatic t_hold();
    boot(8'h03);
    strap_pins = 8'h06;
    repeat (6) @(negedge clk);
    check("R3 mode_code held", {24'd0, mode_code}, 32'h03);
    check("R3 boot_sel held", {28'd0, boot_sel}, 32'h8);
    check("R3 i2c_fast held", {31'd0, i2c_fast}, 0);
    strap_pins = 8'hF7;
    repeat (4) @(negedge clk);
    check("R3 no reserved after capture", {31'd0, reserved_err}, 0);
    check_mode(8'h06);
  endtask

  task automatic t_sync(input int edges_before, input logic [7:0] expect_code);
    @(negedge clk) rst_n = 1'b0;
    strap_pins = 8'h01;
    repeat (5) @(negedge clk);
    strap_pins = 8'h05;
    repeat (edges_before) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 sync latency", {24'd0, mode_code}, {24'd0, expect_code});
  endtask

  initial begin
    t_reset_state();
    t_handover();
    for (int c = 0; c < 8; c++) check_mode(c[7:0]);
    check_mode(8'h08);
    check_mode(8'h83);
    check_mode(8'h42);
    t_hold();
    t_sync(1, 8'h01);
    t_sync(2, 8'h05);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule